// File: doc/BRIEF.md
# AES-256 Key Schedule Generator

This block turns a 256-bit cipher key into the 60 words of the AES-256 key schedule. A one-cycle start strobe captures the key. Over the next 60 cycles the block presents one 32-bit schedule word per cycle, together with its word index and a valid flag. One cycle after the last word it raises a one-cycle done pulse. The byte substitution table, the byte rotation and the round-constant sequence are all built into the block. The substitution table is computed from field arithmetic and is not stored as a table.

The consumer usually writes each word into its own round-key store, using the index as the address. The schedule is produced once per key and then serves every block that is encrypted under that key. A new start is accepted only while the block is idle, and the cycle of the done pulse counts as idle.

Top module: `aes256_key_sched`

## Requirements
- R1: After reset, word_valid and done are both 0 and stay 0 until a start is accepted.
- R2: A start sampled high while idle makes word_valid 1 on the next 60 consecutive cycles. word_idx takes the values 0, 1, …, 59 in order on those cycles, one per cycle.
- R3: Words 0 to 7 are the key words, most significant first. Word 0 is key[255:224] and word 7 is key[31:0].
- R4: For an index i ≥ 8 with i mod 8 = 0, word i equals word i-8 XOR SubWord(RotWord(word i-1)) XOR {rc, 24'h0}. RotWord moves the top byte of a word to the bottom. rc is 8'h01 on the first such word and is multiplied by 2 in GF(2^8) (reduction polynomial 0x11B) on each later one.
- R5: For an index i with i mod 8 = 4 and i ≥ 8, word i equals word i-8 XOR SubWord(word i-1). No rotation and no round constant are applied.
- R6: For all other indices i ≥ 8, word i equals word i-8 XOR word i-1.
- R7: done is 1 for exactly one cycle, the cycle right after the cycle that shows index 59, and word_valid is 0 in that cycle.
- R8: A start raised while words are still being emitted is ignored. The running sequence, its key and its indices do not change.
- R9: A start sampled in the done cycle is accepted. The new key's word 0 then appears on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an expansion of `key` when idle |
| key | input | 256 | Cipher key, sampled with an accepted start |
| word_valid | output | 1 | A schedule word is present this cycle |
| word_idx | output | 6 | Index 0..59 of the present word |
| word_data | output | 32 | Schedule word |
| done | output | 1 | One-cycle pulse after the last word |

## Verification
The embedded assertions check on every cycle that the index advances by exactly one while words are emitted. They also check that done comes only after index 59 and never together with valid, and that the round constant always has a single bit set. Only the bench's reference model can confirm the word values: the substitution results, the rotation choice at each position in the 8-word group, and the constant sequence. The same is true of ignored starts during a run and of a restart issued in the done cycle.

// File: rtl/aes256_key_sched.sv
module aes256_key_sched #(
  parameter int NK = 8,
  parameter int NR = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [32*NK-1:0]  key,
  output logic              word_valid,
  output logic [5:0]        word_idx,
  output logic [31:0]       word_data,
  output logic              done
);
  localparam int WORDS = 4 * (NR + 1);
  localparam int KB    = $clog2(NK);
  localparam int HALF  = NK / 2;

  logic [31:0] win [NK];
  logic [5:0]  idx;
  logic        busy;
  logic [7:0]  rc;

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] v);
    logic [7:0] r, t, b;
    r = 8'h01;
    t = v;
    for (int k = 0; k < 7; k++) begin
      t = gmul(t, t);
      r = gmul(r, t);
    end
    b = r;
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
             ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  wire [KB-1:0] pos     = idx[KB-1:0];
  wire          in_key  = idx < 6'(NK);
  wire [31:0]   last    = win[NK-1];
  wire [31:0]   sub_in  = (pos == '0) ? {last[23:0], last[31:24]} : last;
  logic [31:0]  sub_out;

  for (genvar g = 0; g < 4; g++) begin : g_sub
    assign sub_out[8*g +: 8] = sbox(sub_in[8*g +: 8]);
  end

  logic [31:0] temp;
  always_comb begin
    if (pos == '0)                temp = sub_out ^ {rc, 24'h0};
    else if (pos == KB'(HALF))    temp = sub_out;
    else                          temp = last;
  end

  wire [31:0] fresh = win[0] ^ temp;

  assign word_valid = busy;
  assign word_idx   = idx;
  assign word_data  = in_key ? win[pos] : fresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      rc   <= 8'h01;
      done <= 1'b0;
      for (int j = 0; j < NK; j++) win[j] <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          idx  <= '0;
          rc   <= 8'h01;
          for (int j = 0; j < NK; j++) win[j] <= key[32*(NK-1-j) +: 32];
        end
      end else begin
        if (!in_key) begin
          for (int j = 0; j < NK-1; j++) win[j] <= win[j+1];
          win[NK-1] <= fresh;
          if (pos == '0) rc <= {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1b : 8'h00);
        end
        if (idx == 6'(WORDS-1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 6'd1;
        end
      end
    end
  end

  a_r2_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx != 6'(WORDS-1)) |=> (busy && idx == $past(idx) + 6'd1));

  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy && idx == 6'(WORDS-1)));

  a_r7_done_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !word_valid);

  a_r4_rc_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $onehot(rc));

  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && idx != 6'(WORDS-1)) |=> (idx == $past(idx) + 6'd1));
endmodule

// File: tb/aes256_key_sched_test.sv
module aes256_key_sched_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [255:0] key = '0;
  logic         word_valid, done;
  logic [5:0]   word_idx;
  logic [31:0]  word_data;

  int vectors = 0;
  int errors  = 0;

  always #5 clk = ~clk;

  aes256_key_sched uut (
    .clk(clk), .rst_n(rst_n), .start(start), .key(key),
    .word_valid(word_valid), .word_idx(word_idx),
    .word_data(word_data), .done(done)
  );

  logic [7:0]  sb [256];
  logic [31:0] ks [60];
  int          m_busy = 0, m_idx = 0, m_done = 0;

  function automatic logic [7:0] rl(input logic [7:0] v, input int n);
    return 8'((v << n) | (v >> (8 - n)));
  endfunction

  task automatic build_sbox();
    logic [7:0] p, q;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ 8'(p << 1) ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ 8'(q << 1);
      q = q ^ 8'(q << 2);
      q = q ^ 8'(q << 4);
      if (q[7]) q = q ^ 8'h09;
      sb[p] = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4) ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
  endtask

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  task automatic expand(input logic [255:0] k);
    int rcon;
    logic [31:0] t;
    rcon = 1;
    for (int i = 0; i < 8; i++) ks[i] = k[255 - 32*i -: 32];
    for (int i = 8; i < 60; i++) begin
      t = ks[i-1];
      if (i % 8 == 0) begin
        t = subw({t[23:0], t[31:24]}) ^ {8'(rcon), 24'h0};
        rcon = rcon * 2;
        if (rcon > 255) rcon = rcon ^ 'h11b;
      end else if (i % 8 == 4) begin
        t = subw(t);
      end
      ks[i] = ks[i-8] ^ t;
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      m_done = 0;
      if (m_busy == 0) begin
        if (start) begin
          expand(key);
          m_busy = 1;
          m_idx = 0;
        end
      end else if (m_idx == 59) begin
        m_busy = 0;
        m_done = 1;
      end else begin
        m_idx = m_idx + 1;
      end
    end
  end

  function automatic string tag_of(input int i);
    if (i < 8) return "R3";
    if (i % 8 == 0) return "R4";
    if (i % 8 == 4) return "R5";
    return "R6";
  endfunction

  task automatic compare(input string ctx);
    vectors++;
    if (word_valid !== (m_busy != 0)) begin
      errors++;
      $display("FAIL R2 %s valid got %0b exp %0b", ctx, word_valid, m_busy);
    end
    vectors++;
    if (done !== (m_done != 0)) begin
      errors++;
      $display("FAIL R7 %s done got %0b exp %0b", ctx, done, m_done);
    end
    if (m_busy != 0) begin
      vectors++;
      if (word_idx !== 6'(m_idx)) begin
        errors++;
        $display("FAIL R2 %s idx got %0d exp %0d", ctx, word_idx, m_idx);
      end
      vectors++;
      if (word_data !== ks[m_idx]) begin
        errors++;
        $display("FAIL %s %s word %0d got %h exp %h", tag_of(m_idx), ctx,
                 m_idx, word_data, ks[m_idx]);
      end
    end
  endtask

  task automatic step(input string ctx);
    @(negedge clk);
    compare(ctx);
  endtask

  task automatic run_key(input logic [255:0] k, input string ctx);
    start = 1'b1; key = k;
    step(ctx);
    start = 1'b0;
    for (int c = 0; c < 62; c++) step(ctx);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    build_sbox();
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      vectors++;
      if (word_valid !== 1'b0 || done !== 1'b0) begin
        errors++;
        $display("FAIL R1 reset valid=%0b done=%0b exp 0 0", word_valid, done);
      end
    end
    rst_n = 1'b1;
    for (int c = 0; c < 3; c++) step("R1 idle");

    run_key(256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4, "R3 R4 R5 R6 keyA");
    run_key('0, "R4 zero key");
    run_key({256{1'b1}}, "R5 ones key");
    run_key(256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f, "R6 ramp key");

    start = 1'b1; key = 256'h1;
    step("R8 launch");
    start = 1'b1; key = 256'hdeadbeef;
    for (int c = 0; c < 20; c++) step("R8 start while busy");
    start = 1'b0;
    while (!(m_busy != 0 && m_idx == 59)) step("R8 drain");
    start = 1'b1; key = {8{32'hcafef00d}};
    step("R9 last word");
    step("R9 done cycle");
    start = 1'b0;
    for (int c = 0; c < 62; c++) step("R9 restart");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule